// File: doc/BRIEF.md
# Memory Interface Status Register Bank

This block presents the health of a memory controller and the fill levels of its two data buffers to software. It is a bank of four 32-bit read-only words on a simple memory-mapped slave: a read strobe plus a 2-bit word address, answered one clock later by the data and a read-valid pulse. The bus and the status logic share one clock.

The first word gathers eight live controller status bits with two constants, the bytes per controller word and a signed capacity code. The second and third words carry the read-buffer and write-buffer fill counts. The fourth word holds two sticky flags that remember buffer-full strobes until software reads that word. Reading that word returns the flags as they stood and clears them. If a new full strobe lands in the same cycle as that read, the clear takes priority. Write cycles are accepted on the bus but alter nothing.

Top module: `memstat_regbank`

## Requirements
- R1: A read strobe sampled at a clock edge produces `bus_rvalid` high for exactly the following cycle, with the addressed word on `bus_rdata`. While `bus_rvalid` is low, `bus_rdata` is zero.
- R2: Word 0 (address 0) holds the status bits at these positions: bit 0 done, bit 1 ready (wait-request negated), bit 2 flush active, bit 3 controller reset, bit 4 calibration pass, bit 5 calibration fail, bit 6 read data valid, bit 7 write strobe. Bits 15:8 hold BYTES_PER_WORD, bits 23:16 hold the capacity code, and bits 31:24 are zero.
- R3: Word 1 (address 1) holds `rd_fill`, zero-extended to 32 bits.
- R4: Word 2 (address 2) holds `wr_fill`, zero-extended to 32 bits.
- R5: Word 3 (address 3) has the write-full flag at bit 0 and the read-full flag at bit 1, with all other bits zero. A one-cycle pulse on `wr_full_pulse` or `rd_full_pulse` sets its flag, and the flag stays set until cleared.
- R6: A read of word 3 returns the flags as they were before the read, then clears both flags. Reads of other words leave the flags unchanged.
- R7: When a full pulse coincides with a read of word 3, the clear wins. The returned value does not include the new pulse, and the flag is zero afterwards.
- R8: The capacity code is an 8-bit two's-complement value. A value of 1 or more means that many GiB, and a negative value n means 2^n GiB. The default CAP_CODE of -1 reads as 0xFF.
- R9: A write cycle (`bus_wr` high, `bus_rd` low) produces no read-valid and leaves both sticky flags unchanged at any address.
- R10: Synchronous reset clears both sticky flags and `bus_rvalid`, and `bus_rdata` reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by bus and status logic |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (accepted, ignored) |
| bus_addr | input | 2 | Word address |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid pulse |
| ctl_done | input | 1 | Controller initialisation done |
| ctl_ready | input | 1 | Controller not requesting wait |
| flush_active | input | 1 | Write flush currently enabled |
| ctl_reset | input | 1 | Controller reset asserted |
| cal_pass | input | 1 | Calibration succeeded |
| cal_err | input | 1 | Calibration failed |
| ctl_rdata_vld | input | 1 | Controller read data valid |
| ctl_wr_strobe | input | 1 | Controller write strobe |
| rd_fill | input | RD_FILL_W | Read buffer fill count |
| wr_fill | input | WR_FILL_W | Write buffer fill count |
| wr_full_pulse | input | 1 | Write buffer reached full |
| rd_full_pulse | input | 1 | Read buffer reached full |

## Verification
The bench attacks the read-to-clear word. It checks that the returned value is the pre-clear state, because a design that cleared first would always return zero. It drives a full pulse into the same cycle as the clearing read, where a set-priority design would leave a stale flag. It also checks that reads of other words and write cycles keep the flags, since a design that cleared on any access to address 3, or on any address, would lose events. Extreme fill counts and all-ones status patterns expose truncation, sign extension or bit-order slips in the packed words.

// File: rtl/memstat_pkg.sv
package memstat_pkg;
  localparam int WORD_W      = 32;
  localparam int NUM_WORDS   = 4;
  localparam int ADDR_W      = $clog2(NUM_WORDS);
  localparam int NUM_FLAGS   = 2;
  localparam int STAT_BITS   = 8;
  localparam logic [ADDR_W-1:0] STICKY_ADDR = ADDR_W'(3);

  // Two's-complement capacity field: >=1 is GiB, negative n is 2^n GiB.
  function automatic logic [7:0] cap_field(input int code);
    logic [31:0] c;
    c = 32'(code);
    return c[7:0];
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(
      input logic [STAT_BITS-1:0] bits,
      input logic [7:0]           bpw,
      input logic [7:0]           cap);
    return {8'h00, cap, bpw, bits};
  endfunction
endpackage

// File: rtl/memstat_sticky.sv
module memstat_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)        q_o[i] <= 1'b0;
      else if (clr_i) q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/memstat_rdport.sv
module memstat_rdport #(
  parameter int NW = 4,
  parameter int DW = 32,
  localparam int AW = $clog2(NW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [NW-1:0][DW-1:0] words_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 rvalid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      rdata_o  <= rd_i ? words_i[addr_i] : '0;
    end
  end
endmodule

// File: rtl/memstat_regbank.sv
module memstat_regbank
  import memstat_pkg::*;
#(
  parameter int RD_FILL_W      = 9,
  parameter int WR_FILL_W      = 11,
  parameter int BYTES_PER_WORD = 32,
  parameter int CAP_CODE       = -1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [1:0]           bus_addr,
  output logic [31:0]          bus_rdata,
  output logic                 bus_rvalid,
  input  logic                 ctl_done,
  input  logic                 ctl_ready,
  input  logic                 flush_active,
  input  logic                 ctl_reset,
  input  logic                 cal_pass,
  input  logic                 cal_err,
  input  logic                 ctl_rdata_vld,
  input  logic                 ctl_wr_strobe,
  input  logic [RD_FILL_W-1:0] rd_fill,
  input  logic [WR_FILL_W-1:0] wr_fill,
  input  logic                 wr_full_pulse,
  input  logic                 rd_full_pulse
);
  localparam logic [7:0] BPW_F = 8'(BYTES_PER_WORD);
  localparam logic [7:0] CAP_F = cap_field(CAP_CODE);

  // Named internal events for the bound checker.
  logic                          sticky_clr;
  logic [NUM_FLAGS-1:0]          sticky_set;
  logic [NUM_FLAGS-1:0]          sticky_q;
  logic [STAT_BITS-1:0]          status_bits;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words;

  assign sticky_clr  = bus_rd && (bus_addr == STICKY_ADDR);
  assign sticky_set  = {rd_full_pulse, wr_full_pulse};
  assign status_bits = {ctl_wr_strobe, ctl_rdata_vld, cal_err, cal_pass,
                        ctl_reset, flush_active, ctl_ready, ctl_done};

  assign words[0] = pack_status(status_bits, BPW_F, CAP_F);
  assign words[1] = WORD_W'(rd_fill);
  assign words[2] = WORD_W'(wr_fill);
  assign words[3] = WORD_W'(sticky_q);

  memstat_sticky #(.N(NUM_FLAGS)) u_sticky (
    .clk   (clk),
    .rst   (rst),
    .set_i (sticky_set),
    .clr_i (sticky_clr),
    .q_o   (sticky_q)
  );

  memstat_rdport #(.NW(NUM_WORDS), .DW(WORD_W)) u_rdport (
    .clk      (clk),
    .rst      (rst),
    .rd_i     (bus_rd),
    .addr_i   (bus_addr),
    .words_i  (words),
    .rdata_o  (bus_rdata),
    .rvalid_o (bus_rvalid)
  );
endmodule

// File: rtl/memstat_chk.sv
module memstat_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_rdata,
  input logic        bus_rvalid,
  input logic        wr_full_pulse,
  input logic        rd_full_pulse,
  input logic [1:0]  sticky_q
);
  p_rvalid_after_read_r1: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  p_no_rvalid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
  p_rdata_zero_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !bus_rvalid |-> bus_rdata == 32'h0);
  p_word3_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd3) |=> bus_rdata[31:2] == 30'h0);
  p_set_wr_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_full_pulse && !(bus_rd && bus_addr == 2'd3)) |=> sticky_q[0]);
  p_set_rd_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_full_pulse && !(bus_rd && bus_addr == 2'd3)) |=> sticky_q[1]);
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd3) |=> sticky_q == 2'b00);
  p_returns_old_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd3) |=> bus_rdata[1:0] == $past(sticky_q));
  p_flags_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!(bus_rd && bus_addr == 2'd3) && !wr_full_pulse && !rd_full_pulse) |=> $stable(sticky_q));
  p_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd) |=> !bus_rvalid);
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (sticky_q == 2'b00 && !bus_rvalid));
endmodule

bind memstat_regbank memstat_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_rd        (bus_rd),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_rdata     (bus_rdata),
  .bus_rvalid    (bus_rvalid),
  .wr_full_pulse (wr_full_pulse),
  .rd_full_pulse (rd_full_pulse),
  .sticky_q      (sticky_q)
);

// File: tb/sim_memstat_regbank.sv
module sim_memstat_regbank;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  addr;
    logic [7:0]  st;
    logic [8:0]  rf;
    logic [10:0] wf;
    logic [31:0] exp;
  } vec_t;

  // Expected words: BYTES_PER_WORD=32 -> 0x20, CAP_CODE=-1 -> 0xFF.
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'hA5, 9'h000, 11'h000, 32'h00FF20A5},
    '{2'd0, 8'h00, 9'h000, 11'h000, 32'h00FF2000},
    '{2'd0, 8'hFF, 9'h1FF, 11'h7FF, 32'h00FF20FF},
    '{2'd1, 8'hFF, 9'h1FF, 11'h7FF, 32'h000001FF},
    '{2'd2, 8'hFF, 9'h1FF, 11'h7FF, 32'h000007FF},
    '{2'd1, 8'h00, 9'h006, 11'h400, 32'h00000006},
    '{2'd2, 8'h00, 9'h006, 11'h400, 32'h00000400},
    '{2'd3, 8'h5A, 9'h0AA, 11'h155, 32'h00000000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  st = 8'h00;
  logic [8:0]  rd_fill = '0;
  logic [10:0] wr_fill = '0;
  logic        wr_full_pulse = 1'b0, rd_full_pulse = 1'b0;
  int checks = 0, fails = 0;
  logic [31:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  memstat_regbank u0 (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ctl_done(st[0]), .ctl_ready(st[1]), .flush_active(st[2]), .ctl_reset(st[3]),
    .cal_pass(st[4]), .cal_err(st[5]), .ctl_rdata_vld(st[6]), .ctl_wr_strobe(st[7]),
    .rd_fill(rd_fill), .wr_fill(wr_fill),
    .wr_full_pulse(wr_full_pulse), .rd_full_pulse(rd_full_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a read (optionally with full pulses in the same cycle), sample at next negedge.
  task automatic rd_word(input logic [1:0] a, input logic wp, input logic rp,
                         output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; wr_full_pulse = wp; rd_full_pulse = rp;
    @(negedge clk);
    bus_rd = 1'b0; wr_full_pulse = 1'b0; rd_full_pulse = 1'b0;
    check("R1 rvalid", 32'(bus_rvalid), 32'd1);
    d = bus_rdata;
  endtask

  task automatic pulse(input logic wp, input logic rp);
    @(negedge clk);
    wr_full_pulse = wp; rd_full_pulse = rp;
    @(negedge clk);
    wr_full_pulse = 1'b0; rd_full_pulse = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10 rvalid after reset", 32'(bus_rvalid), 32'd0);
    check("R10 rdata after reset", bus_rdata, 32'd0);
    rd_word(2'd3, 1'b0, 1'b0, got);
    check("R10 flags after reset", got, 32'd0);

    // Vector table: R2 R3 R4 R8
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      st = VECS[i].st; rd_fill = VECS[i].rf; wr_fill = VECS[i].wf;
      rd_word(VECS[i].addr, 1'b0, 1'b0, got);
      check($sformatf("R2/R3/R4/R8 vec%0d", i), got, VECS[i].exp);
      @(negedge clk);
      check("R1 idle rdata zero", bus_rdata, 32'd0);
      check("R1 idle rvalid low", 32'(bus_rvalid), 32'd0);
    end

    // R8: capacity byte alone
    rd_word(2'd0, 1'b0, 1'b0, got);
    check("R8 capacity byte", 32'(got[23:16]), 32'hFF);

    // R5 / R6: set, read returns old, then cleared
    pulse(1'b1, 1'b0);
    rd_word(2'd3, 1'b0, 1'b0, got);
    check("R5 write-full flag bit0", got, 32'd1);
    rd_word(2'd3, 1'b0, 1'b0, got);
    check("R6 cleared after read", got, 32'd0);
    pulse(1'b0, 1'b1);
    rd_word(2'd3, 1'b0, 1'b0, got);
    check("R5 read-full flag bit1", got, 32'd2);
    pulse(1'b1, 1'b1);
    pulse(1'b0, 1'b0);
    rd_word(2'd3, 1'b0, 1'b0, got);
    check("R5 both flags held", got, 32'd3);

    // R6: reads of other words keep flags
    pulse(1'b1, 1'b0);
    rd_word(2'd0, 1'b0, 1'b0, got);
    rd_word(2'd1, 1'b0, 1'b0, got);
    rd_word(2'd2, 1'b0, 1'b0, got);
    rd_word(2'd3, 1'b0, 1'b0, got);
    check("R6 other reads keep flag", got, 32'd1);

    // R7: pulse coincides with clearing read, flags empty before
    rd_word(2'd3, 1'b1, 1'b1, got);
    check("R7 returned value excludes new pulse", got, 32'd0);
    rd_word(2'd3, 1'b0, 1'b0, got);
    check("R7 clear wins over set", got, 32'd0);
    // R7: flag set before, pulse again during clearing read
    pulse(1'b0, 1'b1);
    rd_word(2'd3, 1'b0, 1'b1, got);
    check("R7 returns prior flag", got, 32'd2);
    rd_word(2'd3, 1'b0, 1'b0, got);
    check("R7 flag zero afterwards", got, 32'd0);

    // R9: writes ignored
    pulse(1'b1, 1'b1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd3;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R9 no rvalid on write", 32'(bus_rvalid), 32'd0);
    check("R9 rdata zero on write", bus_rdata, 32'd0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0;
    @(negedge clk);
    bus_wr = 1'b0;
    rd_word(2'd3, 1'b0, 1'b0, got);
    check("R9 flags survive writes", got, 32'd3);

    // R10: reset clears set flags
    pulse(1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 rvalid low after reset", 32'(bus_rvalid), 32'd0);
    rd_word(2'd3, 1'b0, 1'b0, got);
    check("R10 flags cleared by reset", got, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule